// File: doc/BRIEF.md
# Deflection Router Eject/Inject Stage

This block is the pipeline stage that sits ahead of the routing stage in a bufferless deflection router with four network input slots. Each cycle it looks at the four incoming flit slots and compares each valid flit's destination with the local node identifier. It removes at most one flit addressed to this node and hands it to the reassembly interface. Golden-packet flits win that choice, and ties go to the lower-numbered slot. Local flits that lose stay in their slots and travel on, so the routing stage will deflect them.

After ejection the stage offers any empty slot to the head of the local injection FIFO. Injection has the lowest priority. A new flit only ever fills a slot that is already empty, so traffic already in the network is never stalled or displaced. The injected flit takes the lowest-numbered empty slot, and the FIFO pop is raised combinationally in the same cycle.

The slot outputs and the eject port are registered, which makes this a one-cycle stage. There is no state machine: the only state is the stage register.

Top module: `ejinj_stage`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it, all four output slots and the eject port are invalid.
- R2: A valid input flit whose destination equals `local_id` can be ejected. When at least one such flit is present, `ej_valid` is 1 one cycle later and the eject port carries that flit's destination, golden bit, sequence number and data. Otherwise `ej_valid` is 0.
- R3: If any local valid flit has its golden bit set to 1, the ejected flit is a golden one.
- R4: Among the candidates of equal golden standing, the flit in the lowest-numbered slot (slot 0 first) is ejected.
- R5: At most one flit is ejected per cycle. Every other local flit leaves in the slot it arrived in, with its fields unchanged.
- R6: A valid flit whose destination is not `local_id` leaves in the same slot one cycle later, with its fields unchanged.
- R7: `inj_pop` is 1 in the same cycle exactly when `inj_valid` is 1 and at least one slot is empty after ejection. A slot is empty after ejection if its input was invalid or its flit was ejected.
- R8: When `inj_pop` is 1, the FIFO head (destination, golden bit, sequence number, data) appears one cycle later in the lowest-numbered slot that is empty after ejection. Every other empty slot leaves invalid.
- R9: When all four inputs are valid and none is local, no flit is injected and all four flits pass through, whatever `inj_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | NODE_W | Identifier of this node |
| in_valid | input | SLOTS | Per-slot valid bit, bit i for slot i |
| in_dest | input | SLOTS*NODE_W | Per-slot destination, slot i in bits [i*NODE_W +: NODE_W] |
| in_golden | input | SLOTS | Per-slot golden-packet bit |
| in_seq | input | SLOTS*SEQ_W | Per-slot flit sequence number |
| in_data | input | SLOTS*DATA_W | Per-slot payload |
| inj_valid | input | 1 | Injection FIFO not empty |
| inj_dest | input | NODE_W | FIFO head destination |
| inj_golden | input | 1 | FIFO head golden bit |
| inj_seq | input | SEQ_W | FIFO head sequence number |
| inj_data | input | DATA_W | FIFO head payload |
| inj_pop | output | 1 | Pop the FIFO head (combinational) |
| out_valid | output | SLOTS | Valid bits toward the routing stage |
| out_dest | output | SLOTS*NODE_W | Destinations toward the routing stage |
| out_golden | output | SLOTS | Golden bits toward the routing stage |
| out_seq | output | SLOTS*SEQ_W | Sequence numbers toward the routing stage |
| out_data | output | SLOTS*DATA_W | Payloads toward the routing stage |
| ej_valid | output | 1 | Ejected flit present |
| ej_dest | output | NODE_W | Ejected flit destination |
| ej_golden | output | 1 | Ejected flit golden bit |
| ej_seq | output | SEQ_W | Ejected flit sequence number |
| ej_data | output | DATA_W | Ejected flit payload |

## Verification
`inj_pop` depends only on the current inputs, so it is due in the same cycle as the stimulus. The bench samples it 1 ns after driving the inputs on the falling edge, before the next rising edge. The slot outputs and the eject port pass through one register, so they are sampled 1 ns after the rising edge that captures the stimulus. The sweep covers every combination of slot valid bits, local-destination bits, golden bits and FIFO availability, which is 8192 vectors. For each vector the bench derives the expected ejected slot, the injection slot and all four slot contents arithmetically from the requirements.

// File: rtl/ejinj_pkg.sv
package ejinj_pkg;
    parameter int unsigned SLOTS  = 4;
    parameter int unsigned NODE_W = 4;
    parameter int unsigned SEQ_W  = 3;
    parameter int unsigned DATA_W = 8;

    typedef struct packed {
        logic              valid;
        logic [NODE_W-1:0] dest;
        logic              golden;
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
    } flit_t;
endpackage

// File: rtl/ejinj_eject_sel.sv
module ejinj_eject_sel
    import ejinj_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  flit_t               slot_in [SLOTS],
    input  logic [NODE_W-1:0]   local_id,
    output logic [SLOTS-1:0]    ej_oh
);
    logic [SLOTS-1:0] local_mask;
    logic [SLOTS-1:0] gold_mask;
    logic [SLOTS-1:0] cand;

    for (genvar i = 0; i < SLOTS; i++) begin : g_match
        assign local_mask[i] = slot_in[i].valid && (slot_in[i].dest == local_id);
        assign gold_mask[i]  = local_mask[i] && slot_in[i].golden;
    end

    always_comb begin
        cand  = (gold_mask != '0) ? gold_mask : local_mask;
        ej_oh = cand & (~cand + 1'b1);
    end

    AST_ONE_EJECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ej_oh)); // R5
    AST_EJECT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n) (ej_oh & ~local_mask) == '0); // R2
    AST_GOLDEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (gold_mask != '0) |-> ((ej_oh & gold_mask) != '0)); // R3
endmodule

// File: rtl/ejinj_inject_sel.sv
module ejinj_inject_sel
    import ejinj_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOTS-1:0]    free,
    input  logic                inj_valid,
    output logic [SLOTS-1:0]    inj_oh,
    output logic                inj_pop
);
    always_comb begin
        inj_oh  = inj_valid ? (free & (~free + 1'b1)) : '0;
        inj_pop = |inj_oh;
    end

    AST_INJ_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n) (inj_oh & ~free) == '0); // R8
    AST_NO_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n) (free == '0) |-> !inj_pop); // R9
    AST_POP_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n) inj_pop |-> inj_valid); // R7
endmodule

// File: rtl/ejinj_stage.sv
module ejinj_stage
    import ejinj_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NODE_W-1:0]         local_id,
    input  logic [SLOTS-1:0]          in_valid,
    input  logic [SLOTS*NODE_W-1:0]   in_dest,
    input  logic [SLOTS-1:0]          in_golden,
    input  logic [SLOTS*SEQ_W-1:0]    in_seq,
    input  logic [SLOTS*DATA_W-1:0]   in_data,
    input  logic                      inj_valid,
    input  logic [NODE_W-1:0]         inj_dest,
    input  logic                      inj_golden,
    input  logic [SEQ_W-1:0]          inj_seq,
    input  logic [DATA_W-1:0]         inj_data,
    output logic                      inj_pop,
    output logic [SLOTS-1:0]          out_valid,
    output logic [SLOTS*NODE_W-1:0]   out_dest,
    output logic [SLOTS-1:0]          out_golden,
    output logic [SLOTS*SEQ_W-1:0]    out_seq,
    output logic [SLOTS*DATA_W-1:0]   out_data,
    output logic                      ej_valid,
    output logic [NODE_W-1:0]         ej_dest,
    output logic                      ej_golden,
    output logic [SEQ_W-1:0]          ej_seq,
    output logic [DATA_W-1:0]         ej_data
);
    flit_t            slot_in  [SLOTS];
    flit_t            slot_nxt [SLOTS];
    flit_t            slot_q   [SLOTS];
    flit_t            ej_nxt;
    flit_t            ej_q;
    flit_t            inj_flit;
    logic [SLOTS-1:0] ej_oh;
    logic [SLOTS-1:0] inj_oh;
    logic [SLOTS-1:0] free;

    for (genvar i = 0; i < SLOTS; i++) begin : g_unpack
        assign slot_in[i] = '{valid:  in_valid[i],
                              dest:   in_dest[i*NODE_W +: NODE_W],
                              golden: in_golden[i],
                              seq:    in_seq[i*SEQ_W +: SEQ_W],
                              data:   in_data[i*DATA_W +: DATA_W]};
        assign free[i] = !in_valid[i] || ej_oh[i];
    end

    assign inj_flit = '{valid: 1'b1, dest: inj_dest, golden: inj_golden,
                        seq: inj_seq, data: inj_data};

    ejinj_eject_sel u_eject (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_in  (slot_in),
        .local_id (local_id),
        .ej_oh    (ej_oh)
    );

    ejinj_inject_sel u_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .free      (free),
        .inj_valid (inj_valid),
        .inj_oh    (inj_oh),
        .inj_pop   (inj_pop)
    );

    always_comb begin
        ej_nxt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (ej_oh[i]) ej_nxt = ej_nxt | slot_in[i];
            if (inj_oh[i])      slot_nxt[i] = inj_flit;
            else if (free[i])   slot_nxt[i] = '0;
            else                slot_nxt[i] = slot_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ej_q <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else begin
            ej_q <= ej_nxt;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_nxt[i];
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_pack
        assign out_valid[i]                    = slot_q[i].valid;
        assign out_dest[i*NODE_W +: NODE_W]    = slot_q[i].dest;
        assign out_golden[i]                   = slot_q[i].golden;
        assign out_seq[i*SEQ_W +: SEQ_W]       = slot_q[i].seq;
        assign out_data[i*DATA_W +: DATA_W]    = slot_q[i].data;
    end

    assign ej_valid  = ej_q.valid;
    assign ej_dest   = ej_q.dest;
    assign ej_golden = ej_q.golden;
    assign ej_seq    = ej_q.seq;
    assign ej_data   = ej_q.data;

    AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(out_valid) + int'(ej_valid) ==
                          $countones($past(in_valid)) + int'($past(inj_pop)))); // R5
    AST_EJ_DEST_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ej_valid) |-> (ej_dest == $past(local_id))); // R2
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(!rst_n) |-> (out_valid == '0 && !ej_valid)); // R1
endmodule

// File: tb/ejinj_stage_test.sv
module ejinj_stage_test;
    import ejinj_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NODE_W-1:0]       local_id = '0;
    logic [SLOTS-1:0]        in_valid = '0;
    logic [SLOTS*NODE_W-1:0] in_dest = '0;
    logic [SLOTS-1:0]        in_golden = '0;
    logic [SLOTS*SEQ_W-1:0]  in_seq = '0;
    logic [SLOTS*DATA_W-1:0] in_data = '0;
    logic                    inj_valid = 1'b0;
    logic [NODE_W-1:0]       inj_dest = '0;
    logic                    inj_golden = 1'b0;
    logic [SEQ_W-1:0]        inj_seq = '0;
    logic [DATA_W-1:0]       inj_data = '0;
    logic                    inj_pop;
    logic [SLOTS-1:0]        out_valid;
    logic [SLOTS*NODE_W-1:0] out_dest;
    logic [SLOTS-1:0]        out_golden;
    logic [SLOTS*SEQ_W-1:0]  out_seq;
    logic [SLOTS*DATA_W-1:0] out_data;
    logic                    ej_valid;
    logic [NODE_W-1:0]       ej_dest;
    logic                    ej_golden;
    logic [SEQ_W-1:0]        ej_seq;
    logic [DATA_W-1:0]       ej_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ejinj_stage uut (.*);

    localparam logic [NODE_W-1:0] LOCAL = 4'd5;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == '0 && !ej_valid, "R1 reset state", {out_valid, 3'b0, ej_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        local_id = LOCAL;
        inj_dest = 4'd3;
        inj_seq = 3'd7;
        inj_data = 8'hA5;

        for (int v = 0; v < 8192; v++) begin
            logic [3:0] vm, lm, gm;
            logic [3:0] loc, gold, pick, ejm, freem, injm;
            int eidx, iidx;
            bit hv;
            logic [NODE_W-1:0] ed;
            vm = v[3:0];
            lm = v[7:4];
            gm = v[11:8];
            @(negedge clk);
            in_valid  = vm;
            in_golden = gm;
            inj_valid = v[12];
            inj_golden = v[0];
            for (int i = 0; i < SLOTS; i++) begin
                in_dest[i*NODE_W +: NODE_W] = lm[i] ? LOCAL : NODE_W'(8 + i);
                in_seq[i*SEQ_W +: SEQ_W]    = SEQ_W'(i);
                in_data[i*DATA_W +: DATA_W] = {4'(i), vm ^ lm};
            end
            loc  = vm & lm;
            gold = loc & gm;
            pick = (gold != 0) ? gold : loc;
            eidx = -1;
            for (int i = SLOTS - 1; i >= 0; i--) if (pick[i]) eidx = i;
            ejm = (eidx >= 0) ? 4'(1 << eidx) : 4'b0;
            freem = ~vm | ejm;
            iidx = -1;
            if (v[12]) for (int i = SLOTS - 1; i >= 0; i--) if (freem[i]) iidx = i;
            injm = (iidx >= 0) ? 4'(1 << iidx) : 4'b0;

            #1;
            if (freem == 0) check(inj_pop == 1'b0, "R9 no pop when full", inj_pop, 0);
            else check(inj_pop == (iidx >= 0), "R7 pop", inj_pop, (iidx >= 0));

            @(posedge clk);
            #1;
            check(ej_valid == (loc != 0), "R2 eject valid", ej_valid, (loc != 0));
            if (loc != 0) begin
                check(ej_dest == LOCAL, "R2 eject dest", ej_dest, LOCAL);
                if (gold != 0) check(ej_golden == 1'b1, "R3 golden first", ej_golden, 1);
                check(ej_seq == SEQ_W'(eidx) && ej_data == {4'(eidx), vm ^ lm},
                      "R4 lowest slot ejected", {ej_seq, ej_data}, {SEQ_W'(eidx), 4'(eidx), vm ^ lm});
            end
            for (int i = 0; i < SLOTS; i++) begin
                hv = 1'b0;
                ed = '0;
                if (vm[i] && !ejm[i]) begin
                    hv = 1'b1;
                    ed = lm[i] ? LOCAL : NODE_W'(8 + i);
                    check(out_valid[i] && out_dest[i*NODE_W +: NODE_W] == ed &&
                          out_golden[i] == gm[i] && out_seq[i*SEQ_W +: SEQ_W] == SEQ_W'(i) &&
                          out_data[i*DATA_W +: DATA_W] == {4'(i), vm ^ lm},
                          lm[i] ? "R5 local flit kept" : "R6 transit flit kept",
                          {out_valid[i], out_dest[i*NODE_W +: NODE_W], out_data[i*DATA_W +: DATA_W]},
                          {1'b1, ed, 4'(i), vm ^ lm});
                end else if (injm[i]) begin
                    check(out_valid[i] && out_dest[i*NODE_W +: NODE_W] == 4'd3 &&
                          out_golden[i] == v[0] && out_seq[i*SEQ_W +: SEQ_W] == 3'd7 &&
                          out_data[i*DATA_W +: DATA_W] == 8'hA5,
                          "R8 injected slot", {out_valid[i], out_data[i*DATA_W +: DATA_W]}, {1'b1, 8'hA5});
                end else begin
                    check(!out_valid[i], "R8 empty slot", out_valid[i], 0);
                end
                if (hv && ed == '1) check(1'b0, "R6 dest", 0, 1);
            end
        end
        done = 1'b1;
        report();
    end
endmodule